// File: doc/BRIEF.md
# Consumer Clock Source Mux-Divider

This block feeds up to six clock consumers from a shared pool of tick streams, all inside one reference-clock domain. Every input stream is a one-cycle strobe: one auxiliary PLL tick and six frequency-generator ticks. Each consumer owns a 5-bit field in one source register. The upper three bits of that field choose which stream the consumer follows, and the value zero switches the consumer off. The lower two bits pick a divide ratio through a small table. The consumer then emits one output strobe for every group of selected input strobes that the ratio defines.

Software can write and read the whole register in one access. Three per-consumer request strobes handle the usual clock-control operations: switch off, switch back on, and set a divide ratio by value. Switching back on restores the last non-zero source the consumer had. A static parameter picks the table variant, which decides whether a true divide-by-3 exists. On the variant without it, a request for ratio 3 gives divide-by-4.

Top module: `clksrc_mux_div`

## Requirements
- R1: Consumer i (i = 0..NUM_CONS-1) owns register bits [5i+4:5i]. Within a field, bits 4:2 hold the source code and bits 1:0 hold the divide code. A bus write stores these bits, and a read returns them the cycle after the write edge. Register bits above the last field read as zero and ignore writes.
- R2: After reset the register holds the RESET_VAL parameter, with bits outside the fields cleared, and every output tick is low.
- R3: A consumer whose source code is 0 is switched off. It emits no output ticks and its divide count stays cleared.
- R4: Source code 1 follows aux_tick. Source codes 2 to 7 follow gen_tick[0] to gen_tick[5].
- R5: With ALT_DIV3 = 0, divide codes 0, 1, 2 and 3 give ratios 1, 4, 1 and 2. With ALT_DIV3 = 1, code 2 gives ratio 3 and the other codes are unchanged.
- R6: An output tick is high for one cycle, in the cycle after the selected input tick that completes a group of `ratio` selected ticks. Counting starts from the first selected tick after reset.
- R7: When a consumer's field changes, that consumer's count starts over. The next selected tick is counted as the first of a new group.
- R8: A pulse on dis_req[i] sets consumer i's source code to 0 and leaves its divide code unchanged.
- R9: A pulse on en_req[i] writes back the last non-zero source code consumer i held. If the reset source code was 0 and no non-zero code has been written since, it writes code 1.
- R10: ratio_req[i] with ratio_val 1, 2 or 4 writes divide code 0, 3 or 1. ratio_val 3 writes code 2 when ALT_DIV3 = 1 and code 1 (divide-by-4) when ALT_DIV3 = 0. ratio_val 0, 5, 6 and 7 leave the field unchanged.
- R11: A bus write in the same cycle as any request takes precedence, and the requests have no effect. When en_req[i] and dis_req[i] are both high, the disable wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Whole-register write strobe |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Current register contents |
| en_req | input | NUM_CONS | Per-consumer switch-on request |
| dis_req | input | NUM_CONS | Per-consumer switch-off request |
| ratio_req | input | NUM_CONS | Per-consumer divide-ratio request |
| ratio_val | input | 3 | Requested ratio value (1 to 4), shared by all consumers |
| aux_tick | input | 1 | Auxiliary PLL tick strobe |
| gen_tick | input | 6 | Frequency-generator tick strobes |
| cons_tick | output | NUM_CONS | Per-consumer divided tick strobe |

## Verification
A write or request that arrives at a clock edge shows up on reg_rdata as soon as that edge has passed. An output tick shows up one edge after the input tick that completes its group, because it comes out of a single register. The field value used for a tick is the one held before that edge, so a change made at an edge first affects the ticks of the following cycle. The scoreboard queues each expected value when the stimulus is applied at the falling edge and compares it shortly after the next rising edge. Every comparison therefore lands exactly one register stage after its cause, for both table variants side by side.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

    localparam int FIELD_W    = 5;
    localparam int SRC_W      = 3;
    localparam int DIV_W      = 2;
    localparam int CNT_W      = 2;
    localparam int NUM_GEN    = 6;
    localparam int NUM_INPUTS = 2 ** SRC_W;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [DIV_W-1:0] div;
    } cons_field_t;

    typedef enum logic [DIV_W-1:0] {
        DIV_CODE_PASS = 2'd0,
        DIV_CODE_QUAD = 2'd1,
        DIV_CODE_TRI  = 2'd2,
        DIV_CODE_HALF = 2'd3
    } div_code_e;

    typedef struct packed {
        logic             ok;
        logic [DIV_W-1:0] code;
    } ratio_map_t;

    // Terminal count (ratio - 1) for a divide code; the table is non-monotonic.
    function automatic logic [CNT_W-1:0] last_count(logic [DIV_W-1:0] code, bit alt);
        logic [CNT_W-1:0] r;
        case (code)
            DIV_CODE_PASS: r = 2'd0;
            DIV_CODE_QUAD: r = 2'd3;
            DIV_CODE_TRI:  r = alt ? 2'd2 : 2'd0;
            default:       r = 2'd1;
        endcase
        return r;
    endfunction

    // Translate a requested ratio into a divide code; 3 falls back to 4 without the alt table.
    function automatic ratio_map_t map_ratio(logic [2:0] ratio, bit alt);
        ratio_map_t m;
        m.ok = 1'b1;
        case (ratio)
            3'd1:    m.code = DIV_CODE_PASS;
            3'd2:    m.code = DIV_CODE_HALF;
            3'd3:    m.code = alt ? DIV_CODE_TRI : DIV_CODE_QUAD;
            3'd4:    m.code = DIV_CODE_QUAD;
            default: begin
                m.ok   = 1'b0;
                m.code = DIV_CODE_PASS;
            end
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ccs_field_bank.sv
module ccs_field_bank
    import ccs_pkg::*;
#(
    parameter int          NUM_CONS  = 6,
    parameter bit          ALT_DIV3  = 1'b0,
    parameter logic [31:0] RESET_VAL = 32'h0,
    localparam int         FB        = NUM_CONS * FIELD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [FB-1:0]       wdata,
    input  logic [NUM_CONS-1:0] en_req,
    input  logic [NUM_CONS-1:0] dis_req,
    input  logic [NUM_CONS-1:0] ratio_req,
    input  logic [2:0]          ratio_val,
    output logic [FB-1:0]       fld_vec
);

    ratio_map_t rmap;
    assign rmap = map_ratio(ratio_val, ALT_DIV3);

    for (genvar i = 0; i < NUM_CONS; i++) begin : g_field
        localparam cons_field_t      RST_F   = cons_field_t'(RESET_VAL[i*FIELD_W +: FIELD_W]);
        localparam logic [SRC_W-1:0] RST_SRC = RESET_VAL[i*FIELD_W+DIV_W +: SRC_W];
        localparam logic [SRC_W-1:0] RST_REM = (RST_SRC != '0) ? RST_SRC : SRC_W'(1);

        cons_field_t      fld_q;
        logic [SRC_W-1:0] rem_q;
        cons_field_t      wr_f;

        assign wr_f = cons_field_t'(wdata[i*FIELD_W +: FIELD_W]);

        always_ff @(posedge clk) begin
            if (rst) begin
                fld_q <= RST_F;
                rem_q <= RST_REM;
            end else if (wr) begin
                fld_q <= wr_f;
                if (wr_f.src != '0) begin
                    rem_q <= wr_f.src;
                end
            end else begin
                if (dis_req[i]) begin
                    fld_q.src <= '0;
                end else if (en_req[i]) begin
                    fld_q.src <= rem_q;
                end
                if (ratio_req[i] && rmap.ok) begin
                    fld_q.div <= rmap.code;
                end
            end
        end

        assign fld_vec[i*FIELD_W +: FIELD_W] = fld_q;
    end

endmodule

// File: rtl/ccs_tick_select.sv
module ccs_tick_select
    import ccs_pkg::*;
(
    input  logic [SRC_W-1:0]   src,
    input  logic               aux_tick,
    input  logic [NUM_GEN-1:0] gen_tick,
    output logic               sel_tick
);

    logic [NUM_INPUTS-1:0] pool;

    // Position 0 is the switched-off source and never ticks.
    assign pool     = {gen_tick, aux_tick, 1'b0};
    assign sel_tick = pool[src];

endmodule

// File: rtl/ccs_divider.sv
module ccs_divider
    import ccs_pkg::*;
#(
    parameter bit          ALT_DIV3  = 1'b0,
    parameter cons_field_t RST_FIELD = '0
) (
    input  logic        clk,
    input  logic        rst,
    input  cons_field_t field,
    input  logic        sel_tick,
    output logic        tick_q
);

    cons_field_t      field_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] eff_cnt;
    logic [CNT_W-1:0] last;
    logic             on;
    logic             restart;
    logic             hit;

    assign on      = (field.src != '0);
    assign restart = (field != field_q);
    assign eff_cnt = restart ? '0 : cnt_q;
    assign last    = last_count(field.div, ALT_DIV3);
    assign hit     = on && sel_tick && (eff_cnt == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            field_q <= RST_FIELD;
            cnt_q   <= '0;
            tick_q  <= 1'b0;
        end else begin
            field_q <= field;
            tick_q  <= hit;
            if (!on) begin
                cnt_q <= '0;
            end else if (sel_tick) begin
                cnt_q <= hit ? '0 : eff_cnt + 1'b1;
            end else begin
                cnt_q <= eff_cnt;
            end
        end
    end

endmodule

// File: rtl/clksrc_mux_div.sv
module clksrc_mux_div
    import ccs_pkg::*;
#(
    parameter int          NUM_CONS  = 6,
    parameter int          REG_W     = 32,
    parameter bit          ALT_DIV3  = 1'b0,
    parameter logic [31:0] RESET_VAL = 32'h0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [NUM_CONS-1:0] en_req,
    input  logic [NUM_CONS-1:0] dis_req,
    input  logic [NUM_CONS-1:0] ratio_req,
    input  logic [2:0]          ratio_val,
    input  logic                aux_tick,
    input  logic [5:0]          gen_tick,
    output logic [NUM_CONS-1:0] cons_tick
);

    localparam int FB = NUM_CONS * FIELD_W;

    logic [FB-1:0] fld_vec;

    ccs_field_bank #(
        .NUM_CONS  (NUM_CONS),
        .ALT_DIV3  (ALT_DIV3),
        .RESET_VAL (RESET_VAL)
    ) bank_i (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .wdata     (reg_wdata[FB-1:0]),
        .en_req    (en_req),
        .dis_req   (dis_req),
        .ratio_req (ratio_req),
        .ratio_val (ratio_val),
        .fld_vec   (fld_vec)
    );

    assign reg_rdata = REG_W'(fld_vec);

    if (REG_W > FB) begin : g_pad
        logic unused_pad;
        assign unused_pad = ^reg_wdata[REG_W-1:FB];
    end

    for (genvar i = 0; i < NUM_CONS; i++) begin : g_cons
        cons_field_t cur;
        logic        sel;

        assign cur = cons_field_t'(fld_vec[i*FIELD_W +: FIELD_W]);

        ccs_tick_select sel_i (
            .src      (cur.src),
            .aux_tick (aux_tick),
            .gen_tick (gen_tick),
            .sel_tick (sel)
        );

        ccs_divider #(
            .ALT_DIV3  (ALT_DIV3),
            .RST_FIELD (cons_field_t'(RESET_VAL[i*FIELD_W +: FIELD_W]))
        ) div_i (
            .clk      (clk),
            .rst      (rst),
            .field    (cur),
            .sel_tick (sel),
            .tick_q   (cons_tick[i])
        );
    end

endmodule

// File: rtl/ccs_mux_div_chk.sv
module ccs_mux_div_chk
    import ccs_pkg::*;
#(
    parameter int NUM_CONS = 6,
    parameter int REG_W    = 32,
    parameter bit ALT_DIV3 = 1'b0
) (
    input logic                clk,
    input logic                rst,
    input logic                reg_wr,
    input logic [REG_W-1:0]    reg_rdata,
    input logic [NUM_CONS-1:0] en_req,
    input logic [NUM_CONS-1:0] dis_req,
    input logic                aux_tick,
    input logic [5:0]          gen_tick,
    input logic [NUM_CONS-1:0] cons_tick
);

    localparam int FB = NUM_CONS * FIELD_W;

    logic [NUM_CONS-1:0]   on_vec;
    logic [NUM_CONS-1:0]   sel_vec;
    logic [NUM_CONS-1:0]   one_vec;
    logic [NUM_INPUTS-1:0] pool;
    logic [NUM_CONS-1:0]   en_only;

    assign pool    = {gen_tick, aux_tick, 1'b0};
    assign en_only = en_req & ~dis_req;

    always_comb begin
        for (int i = 0; i < NUM_CONS; i++) begin
            on_vec[i]  = (reg_rdata[i*FIELD_W+DIV_W +: SRC_W] != '0);
            sel_vec[i] = pool[reg_rdata[i*FIELD_W+DIV_W +: SRC_W]];
            one_vec[i] = on_vec[i] && (last_count(reg_rdata[i*FIELD_W +: DIV_W], ALT_DIV3) == '0);
        end
    end

    assert_pad_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata >> FB) == '0);

    assert_off_silent_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((cons_tick & ~$past(on_vec)) == '0));

    assert_tick_cause_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((cons_tick & ~$past(sel_vec)) == '0));

    assert_ratio_one_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((cons_tick & $past(sel_vec & one_vec)) == $past(sel_vec & one_vec)));

    assert_dis_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr && (dis_req != '0)) |=> ((on_vec & $past(dis_req)) == '0));

    assert_en_restores_R9: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr && (en_only != '0)) |=> ((~on_vec & $past(en_only)) == '0));

endmodule

bind clksrc_mux_div ccs_mux_div_chk #(
    .NUM_CONS (NUM_CONS),
    .REG_W    (REG_W),
    .ALT_DIV3 (ALT_DIV3)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .en_req    (en_req),
    .dis_req   (dis_req),
    .aux_tick  (aux_tick),
    .gen_tick  (gen_tick),
    .cons_tick (cons_tick)
);

// File: tb/clksrc_mux_div_tb_top.sv
module clksrc_mux_div_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          NC         = 6;
    localparam int          RW         = 32;
    localparam logic [31:0] FMASK      = 32'h3FFF_FFFF;
    localparam logic [31:0] ALT_RST    = 32'h0000_0014;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [RW-1:0] reg_wdata = '0;
    logic [NC-1:0] en_req = '0, dis_req = '0, ratio_req = '0;
    logic [2:0]    ratio_val = '0;
    logic          aux_tick = 1'b0;
    logic [5:0]    gen_tick = '0;
    logic [RW-1:0] rd0, rd1;
    logic [NC-1:0] tk0, tk1;

    always #(CLK_PERIOD/2) clk = ~clk;

    clksrc_mux_div #(.NUM_CONS(NC), .REG_W(RW), .ALT_DIV3(1'b0), .RESET_VAL(32'h0)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(rd0),
        .en_req(en_req), .dis_req(dis_req), .ratio_req(ratio_req), .ratio_val(ratio_val),
        .aux_tick(aux_tick), .gen_tick(gen_tick), .cons_tick(tk0));

    clksrc_mux_div #(.NUM_CONS(NC), .REG_W(RW), .ALT_DIV3(1'b1), .RESET_VAL(ALT_RST)) dut_alt_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(rd1),
        .en_req(en_req), .dis_req(dis_req), .ratio_req(ratio_req), .ratio_val(ratio_val),
        .aux_tick(aux_tick), .gen_tick(gen_tick), .cons_tick(tk1));

    // Reference state, index 0 = default table, index 1 = alternate table.
    logic [31:0] m_reg  [2];
    logic [2:0]  m_rem  [2][NC];
    logic [1:0]  m_cnt  [2][NC];
    logic [4:0]  m_prev [2][NC];

    logic [5:0]  q_t0[$], q_t1[$];
    logic [31:0] q_r0[$], q_r1[$];
    string       q_req[$];
    string       cur_req = "R2";
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    function automatic int ratio_of(logic [1:0] c, bit alt);
        case (c)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return alt ? 3 : 1;
            default: return 2;
        endcase
    endfunction

    task automatic model_reset(input int k, input logic [31:0] rv);
        m_reg[k] = rv & FMASK;
        for (int i = 0; i < NC; i++) begin
            m_rem[k][i]  = (rv[i*5+2 +: 3] != 3'd0) ? rv[i*5+2 +: 3] : 3'd1;
            m_cnt[k][i]  = 2'd0;
            m_prev[k][i] = rv[i*5 +: 5];
        end
    endtask

    task automatic model_step(input int k, input bit alt, output logic [5:0] tk);
        logic [7:0]  pool;
        logic [31:0] r;
        logic [4:0]  f;
        logic [1:0]  eff, last;
        logic        sel, hit;
        pool = {gen_tick, aux_tick, 1'b0};
        tk = '0;
        for (int i = 0; i < NC; i++) begin
            f    = m_reg[k][i*5 +: 5];
            last = 2'(ratio_of(f[1:0], alt) - 1);
            sel  = pool[f[4:2]];
            eff  = (f != m_prev[k][i]) ? 2'd0 : m_cnt[k][i];
            if (f[4:2] == 3'd0) begin
                m_cnt[k][i] = 2'd0;
            end else begin
                hit = sel && (eff == last);
                tk[i] = hit;
                m_cnt[k][i] = sel ? (hit ? 2'd0 : eff + 2'd1) : eff;
            end
            m_prev[k][i] = f;
        end
        r = m_reg[k];
        if (reg_wr) begin
            r = reg_wdata & FMASK;
            for (int i = 0; i < NC; i++)
                if (r[i*5+2 +: 3] != 3'd0) m_rem[k][i] = r[i*5+2 +: 3];
        end else begin
            for (int i = 0; i < NC; i++) begin
                if (dis_req[i])     r[i*5+2 +: 3] = 3'd0;
                else if (en_req[i]) r[i*5+2 +: 3] = m_rem[k][i];
                if (ratio_req[i]) begin
                    case (ratio_val)
                        3'd1: r[i*5 +: 2] = 2'd0;
                        3'd2: r[i*5 +: 2] = 2'd3;
                        3'd3: r[i*5 +: 2] = alt ? 2'd2 : 2'd1;
                        3'd4: r[i*5 +: 2] = 2'd1;
                        default: ;
                    endcase
                end
            end
        end
        m_reg[k] = r;
    endtask

    // Driver: apply one cycle of stimulus at the falling edge, queue the expected result.
    task automatic cyc(input logic wr, input logic [31:0] wd, input logic [NC-1:0] en,
                       input logic [NC-1:0] dis, input logic [NC-1:0] rr, input logic [2:0] rv);
        logic [5:0] e0, e1;
        @(negedge clk);
        reg_wr    = wr;
        reg_wdata = wd;
        en_req    = en;
        dis_req   = dis;
        ratio_req = rr;
        ratio_val = rv;
        aux_tick  = 1'($urandom);
        gen_tick  = 6'($urandom);
        model_step(0, 1'b0, e0);
        model_step(1, 1'b1, e1);
        q_t0.push_back(e0);
        q_t1.push_back(e1);
        q_r0.push_back(m_reg[0]);
        q_r1.push_back(m_reg[1]);
        q_req.push_back(cur_req);
    endtask

    task automatic idle(input int n);
        for (int j = 0; j < n; j++) cyc(1'b0, '0, '0, '0, '0, 3'd0);
    endtask

    task automatic wr_reg(input logic [31:0] d);
        cyc(1'b1, d, '0, '0, '0, 3'd0);
    endtask

    function automatic logic [31:0] pack_fields(input logic [2:0] s [NC], input logic [1:0] c [NC]);
        logic [31:0] d = '0;
        for (int i = 0; i < NC; i++) d[i*5 +: 5] = {s[i], c[i]};
        return d;
    endfunction

    // Monitor: compare shortly after each rising edge.
    always @(posedge clk) begin
        #1;
        if (q_t0.size() != 0) begin
            logic [5:0]  e0, e1;
            logic [31:0] r0, r1;
            string       rq;
            e0 = q_t0.pop_front();
            e1 = q_t1.pop_front();
            r0 = q_r0.pop_front();
            r1 = q_r1.pop_front();
            rq = q_req.pop_front();
            checks++;
            if (tk0 !== e0 || tk1 !== e1 || rd0 !== r0 || rd1 !== r1) begin
                fails++;
                $display("FAIL %s: tick dflt=%b exp=%b alt=%b exp=%b rdata dflt=%h exp=%h alt=%h exp=%h",
                         rq, tk0, e0, tk1, e1, rd0, r0, rd1, r1);
            end
        end
    end

    initial begin
        logic [2:0] s [NC];
        logic [1:0] c [NC];
        model_reset(0, 32'h0);
        model_reset(1, ALT_RST);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R2: reset state at the ports
        checks++;
        if (rd0 !== 32'h0 || rd1 !== ALT_RST || tk0 !== '0 || tk1 !== '0) begin
            fails++;
            $display("FAIL R2: rdata dflt=%h exp=0 alt=%h exp=%h tick dflt=%b alt=%b exp=0",
                     rd0, rd1, ALT_RST, tk0, tk1);
        end
        cur_req = "R2";
        idle(6);

        // R9: switch-on straight after reset restores code 1 (or the reset code)
        cur_req = "R9";
        cyc(1'b0, '0, 6'h3F, '0, '0, 3'd0);
        idle(8);

        // R1: field layout and pad bits
        cur_req = "R1";
        wr_reg(32'hFFFF_FFFF);
        idle(4);
        wr_reg(32'h1234_5678);
        idle(4);
        wr_reg(32'hC000_0000);
        idle(2);

        // R4: every source code reaches its input
        cur_req = "R4";
        for (int i = 0; i < NC; i++) begin s[i] = 3'(i + 2); c[i] = 2'd0; end
        wr_reg(pack_fields(s, c));
        idle(16);
        for (int i = 0; i < NC; i++) begin s[i] = 3'(7 - i); c[i] = 2'd0; end
        wr_reg(pack_fields(s, c));
        idle(16);
        for (int i = 0; i < NC; i++) begin s[i] = 3'd1; c[i] = 2'd2; end
        wr_reg(pack_fields(s, c));
        idle(16);

        // R5: all four divide codes on both tables
        cur_req = "R5";
        for (int i = 0; i < NC; i++) begin s[i] = 3'd2; c[i] = 2'(i % 4); end
        wr_reg(pack_fields(s, c));
        idle(40);
        for (int i = 0; i < NC; i++) begin s[i] = 3'd1; c[i] = 2'((3 - i) % 4); end
        wr_reg(pack_fields(s, c));
        idle(40);

        // R6: output tick timing for divide-by-4 groups
        cur_req = "R6";
        for (int i = 0; i < NC; i++) begin s[i] = 3'(i + 2); c[i] = 2'd1; end
        wr_reg(pack_fields(s, c));
        idle(40);

        // R3: switched-off consumers stay silent
        cur_req = "R3";
        for (int i = 0; i < NC; i++) begin s[i] = 3'd0; c[i] = 2'(i % 4); end
        wr_reg(pack_fields(s, c));
        idle(12);

        // R7: field changes restart the count
        cur_req = "R7";
        for (int i = 0; i < NC; i++) begin s[i] = 3'd1; c[i] = 2'd1; end
        wr_reg(pack_fields(s, c));
        idle(5);
        for (int i = 0; i < NC; i++) c[i] = 2'd3;
        wr_reg(pack_fields(s, c));
        idle(7);
        for (int i = 0; i < NC; i++) begin s[i] = 3'd3; c[i] = 2'd1; end
        wr_reg(pack_fields(s, c));
        idle(3);
        for (int i = 0; i < NC; i++) s[i] = 3'd1;
        wr_reg(pack_fields(s, c));
        idle(12);

        // R8: switch-off keeps the divide code
        cur_req = "R8";
        for (int i = 0; i < NC; i++) begin s[i] = 3'(7 - i); c[i] = 2'(i % 4); end
        wr_reg(pack_fields(s, c));
        idle(3);
        cyc(1'b0, '0, '0, 6'b101010, '0, 3'd0);
        idle(10);

        // R9: switch-on restores the last non-zero source after a zero write
        cur_req = "R9";
        cyc(1'b0, '0, 6'b101010, '0, '0, 3'd0);
        idle(4);
        wr_reg(32'h0000_0000);
        idle(3);
        cyc(1'b0, '0, 6'h3F, '0, '0, 3'd0);
        idle(10);

        // R10: ratio requests, valid and ignored values
        cur_req = "R10";
        cyc(1'b0, '0, '0, '0, 6'h3F, 3'd3);
        idle(12);
        cyc(1'b0, '0, '0, '0, 6'b000111, 3'd2);
        idle(8);
        cyc(1'b0, '0, '0, '0, 6'b111000, 3'd4);
        idle(8);
        cyc(1'b0, '0, '0, '0, 6'h3F, 3'd0);
        cyc(1'b0, '0, '0, '0, 6'h3F, 3'd5);
        cyc(1'b0, '0, '0, '0, 6'h3F, 3'd7);
        idle(6);
        cyc(1'b0, '0, '0, '0, 6'b010101, 3'd1);
        idle(8);

        // R11: bus write beats requests, disable beats enable
        cur_req = "R11";
        cyc(1'b1, 32'h0842_1084, 6'h3F, 6'b000011, 6'h3F, 3'd2);
        idle(6);
        cyc(1'b0, '0, 6'h3F, 6'b000111, '0, 3'd0);
        idle(10);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule